// File: doc/BRIEF.md
# Atomic Lock-Hold Timeout Monitor

This block sits beside the L1 data cache of an out-of-order core that lets atomic read-modify-write operations run without surrounding fences. Each atomic locks its cache line when its load half obtains the line. It releases the lock when its store half is performed in the L1. The monitor receives both events, each tagged with the reorder-buffer serial of the atomic. It keeps the outstanding atomics in arrival order and measures how long the oldest one has held its lock.

If that hold time reaches a programmable limit, the monitor raises a flush request carrying the serial of the oldest atomic. The core then squashes and re-executes everything from that instruction onward. This drops the lock and lets a competing core move forward. One timeout covers every deadlock pattern between cores: a store stuck behind a foreign lock, a load wedged between lock and unlock, and an eviction that is refused because the line is locked.

The request stays up until the pipeline acknowledges it. The acknowledgement then wipes all tracked atomics and the counter. A limit of zero switches the monitor off.

Top module: `atomic_watchdog`

## Requirements
- R1: While reset is low, and on the first cycle after reset, `flush_req` is 0 and `flush_serial` is 0.
- R2: Suppose an atomic is the oldest tracked entry from clock edge E, with `threshold` = T > 0. If no release of that atomic is sampled on edges E+1 to E+T, `flush_req` rises at edge E+T.
- R3: A release of the oldest atomic sampled on any edge up to and including E+T prevents the flush. When the release and the expiry fall on the same edge, the release wins.
- R4: When `flush_req` rises, `flush_serial` equals the serial of the oldest tracked atomic.
- R5: Atomics are aged by the order of their `acq_valid` events. When the oldest is released at edge R, the next one becomes oldest and its timing starts fresh from R, so it fires at R+T.
- R6: Releasing an atomic that is not the oldest removes only that entry. The timing of the oldest is not disturbed.
- R7: With `threshold` = 0, `flush_req` never rises.
- R8: `flush_req` stays high, with `flush_serial` unchanged, until `flush_ack` is sampled high.
- R9: The edge that samples `flush_ack` with `flush_req` high clears `flush_req`, the counter and every tracked atomic. Atomics acquired before that edge can no longer cause a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_valid | input | 1 | An atomic's load half has locked its line |
| acq_serial | input | SER_W | ROB serial of the locking atomic |
| rel_valid | input | 1 | An atomic's store half has been performed and has unlocked the line |
| rel_serial | input | SER_W | ROB serial of the unlocking atomic |
| threshold | input | CNT_W | Lock-hold limit in cycles; 0 disables |
| flush_ack | input | 1 | Pipeline has completed the requested flush |
| flush_req | output | 1 | Flush request |
| flush_serial | output | SER_W | ROB serial to flush from |

## Verification
A corrupted age order or a failed compaction shows up as a wrong `flush_serial` on the edge the request rises. It can also show up as a flush that arrives too early or too late relative to the release edge; the error lands within one threshold period. A counter that fails to restart on a head change shifts the flush edge by the time already spent on the previous oldest. Stale entries left after an acknowledgement surface as a spurious request one threshold period later. The bench therefore pins the exact rising edge and serial in each scenario.

// File: rtl/awd_pkg.sv
// Package: shared types for the atomic lock-hold monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package awd_pkg;

    // Flush controller state.
    typedef enum logic {
        AWD_WATCH = 1'b0,
        AWD_FLUSH = 1'b1
    } awd_state_e;

endpackage

// File: rtl/awd_age_queue.sv
// Age-ordered list of atomics that hold a line lock.
// Entry 0 is the oldest. Valid entries stay packed from index 0.
// A release removes the first entry whose serial matches, and the younger
// entries shift down. An acquire appends behind the youngest.
// Assumes: at most DEPTH atomics outstanding; an acquire while full is dropped.
module awd_age_queue #(
    parameter int DEPTH = 4,
    parameter int SER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             acq_valid,
    input  logic [SER_W-1:0] acq_serial,
    input  logic             rel_valid,
    input  logic [SER_W-1:0] rel_serial,
    output logic             head_valid,
    output logic [SER_W-1:0] head_serial,
    output logic             head_pop
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q, valid_d;
    logic [SER_W-1:0] ser_q [DEPTH];
    logic [SER_W-1:0] ser_d [DEPTH];
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             placed;

    // Locate the first entry matching the release serial.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && rel_valid && valid_q[i] && ser_q[i] == rel_serial) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Build the next list: remove the released entry, then append the acquire.
    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < DEPTH; i++) ser_d[i] = ser_q[i];
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (hit && i >= int'(hit_idx)) begin
                valid_d[i] = valid_q[i+1];
                ser_d[i]   = ser_q[i+1];
            end
        end
        if (hit) begin
            valid_d[DEPTH-1] = 1'b0;
            ser_d[DEPTH-1]   = '0;
        end
        placed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (acq_valid && !placed && !valid_d[i]) begin
                valid_d[i] = 1'b1;
                ser_d[i]   = acq_serial;
                placed     = 1'b1;
            end
        end
    end

    // Register the list; reset or acknowledge empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) ser_q[i] <= '0;
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < DEPTH; i++) ser_q[i] <= ser_d[i];
        end
    end

    assign head_valid  = valid_q[0];
    assign head_serial = ser_q[0];
    assign head_pop    = hit && (hit_idx == '0);

    // R5: valid entries remain packed toward the oldest slot.
    generate
        for (genvar g = 0; g < DEPTH - 1; g++) begin : g_pack
            assert_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
                valid_q[g+1] |-> valid_q[g]);
        end
    endgenerate

    // R9: an acknowledged flush leaves no tracked atomic.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0));

endmodule

// File: rtl/awd_hold_timer.sv
// Counts the cycles for which the current oldest atomic has held its lock.
// It raises expire when the count reaches threshold - 1 and the oldest is
// not being released in the same cycle.
// Assumes: restart pulses in the cycle the oldest entry is removed.
module awd_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             restart,
    input  logic             freeze,
    input  logic [CNT_W-1:0] threshold,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Advance the hold count; restart on a new oldest, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || restart || !run) begin
            cnt_q <= '0;
        end else if (!freeze && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry: enabled, oldest still held, and limit reached.
    always_comb begin
        expire = run && !restart && !freeze && (threshold != '0)
                 && (cnt_q >= threshold - 1'b1);
    end

    // R5: a change of the oldest entry starts its count from zero.
    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/awd_flush_ctrl.sv
// Turns an expiry into a held flush request and latches the flush serial.
// The request drops on the acknowledgement edge, which also issues clear.
// Assumes: flush_ack is only meaningful while flush_req is high.
module awd_flush_ctrl
    import awd_pkg::*;
#(
    parameter int SER_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic [SER_W-1:0] head_serial,
    input  logic             flush_ack,
    output logic             flush_req,
    output logic [SER_W-1:0] flush_serial,
    output logic             clear
);
    awd_state_e       state_q;
    logic [SER_W-1:0] ser_q;

    // Move between watching and waiting for the flush to complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AWD_WATCH;
            ser_q   <= '0;
        end else begin
            case (state_q)
                AWD_WATCH: if (expire) begin
                    state_q <= AWD_FLUSH;
                    ser_q   <= head_serial;
                end
                AWD_FLUSH: if (flush_ack) state_q <= AWD_WATCH;
                default:   state_q <= AWD_WATCH;
            endcase
        end
    end

    assign flush_req    = (state_q == AWD_FLUSH);
    assign flush_serial = ser_q;
    assign clear        = flush_req && flush_ack;

    // R4: the request carries the serial of the oldest atomic at expiry.
    assert_fire_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> (flush_serial == $past(head_serial)));

    // R9: an acknowledgement drops the request.
    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> !flush_req);

endmodule

// File: rtl/atomic_watchdog.sv
// Top level of the atomic lock-hold monitor.
// It times the oldest atomic that holds a cache-line lock and requests a
// pipeline flush from that atomic's ROB serial when the hold outlasts the
// threshold.
// Assumes: acquire and release events are single-cycle pulses tagged with
// distinct serials for the atomics in flight.
module atomic_watchdog #(
    parameter int DEPTH = 4,
    parameter int SER_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_valid,
    input  logic [SER_W-1:0] acq_serial,
    input  logic             rel_valid,
    input  logic [SER_W-1:0] rel_serial,
    input  logic [CNT_W-1:0] threshold,
    input  logic             flush_ack,
    output logic             flush_req,
    output logic [SER_W-1:0] flush_serial
);
    logic             head_valid;
    logic [SER_W-1:0] head_serial;
    logic             head_pop;
    logic             expire;
    logic             clear;

    awd_age_queue #(.DEPTH(DEPTH), .SER_W(SER_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .acq_valid   (acq_valid),
        .acq_serial  (acq_serial),
        .rel_valid   (rel_valid),
        .rel_serial  (rel_serial),
        .head_valid  (head_valid),
        .head_serial (head_serial),
        .head_pop    (head_pop)
    );

    awd_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .run       (head_valid),
        .restart   (head_pop),
        .freeze    (flush_req),
        .threshold (threshold),
        .expire    (expire)
    );

    awd_flush_ctrl #(.SER_W(SER_W)) u_flush (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .head_serial  (head_serial),
        .flush_ack    (flush_ack),
        .flush_req    (flush_req),
        .flush_serial (flush_serial),
        .clear        (clear)
    );

    // R7: a zero threshold never starts a flush.
    assert_thr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold == '0 && !flush_req) |=> !flush_req);

    // R3: releasing the oldest wins over an expiry in the same cycle.
    assert_release_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pop && !flush_req) |=> !flush_req);

    // R8: the request and its serial hold until acknowledged.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> (flush_req && $stable(flush_serial)));

endmodule

// File: tb/atomic_watchdog_tb.sv
module atomic_watchdog_tb;
    localparam int SER_W = 6;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_valid = 1'b0;
    logic [SER_W-1:0] acq_serial = '0;
    logic             rel_valid = 1'b0;
    logic [SER_W-1:0] rel_serial = '0;
    logic [CNT_W-1:0] threshold = '0;
    logic             flush_ack = 1'b0;
    logic             flush_req;
    logic [SER_W-1:0] flush_serial;

    int checks = 0;
    int failures = 0;

    // Each vector: threshold, serial, edge offset of the release.
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{5, 3, 3}, '{5, 7, 5}, '{5, 9, 6}, '{1, 2, 2},
        '{1, 4, 1}, '{0, 6, 40}, '{12, 11, 20}, '{3, 15, 10}
    };

    atomic_watchdog #(.DEPTH(4), .SER_W(SER_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acq_valid(acq_valid), .acq_serial(acq_serial),
        .rel_valid(rel_valid), .rel_serial(rel_serial),
        .threshold(threshold), .flush_ack(flush_ack),
        .flush_req(flush_req), .flush_serial(flush_serial)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic do_ack();
        flush_ack = 1'b1;
        step();
        flush_ack = 1'b0;
        chk("R9 request dropped after ack", int'(flush_req), 0);
    endtask

    // One atomic: acquire at E0, release at E0+rel_after unless a flush comes first.
    task automatic run_case(input int thr, input int ser, input int rel_after);
        int  fired_at;
        bit  exp_fire;
        fired_at = 0;
        threshold = CNT_W'(thr);
        acq_valid = 1'b1;
        acq_serial = SER_W'(ser);
        step();
        acq_valid = 1'b0;
        for (int k = 1; k <= rel_after; k++) begin
            rel_valid = (k == rel_after);
            rel_serial = SER_W'(ser);
            step();
            rel_valid = 1'b0;
            if (flush_req) begin
                fired_at = k;
                break;
            end
        end
        exp_fire = (thr != 0) && (thr < rel_after);
        if (exp_fire) begin
            chk("R2 flush edge", fired_at, thr);
            chk("R4 flush serial", int'(flush_serial), ser);
            do_ack();
        end else begin
            chk("R3/R7 no flush", fired_at, 0);
            for (int k = 0; k < thr + 2; k++) step();
            chk("R3/R7 quiet afterwards", int'(flush_req), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int early;
        @(negedge clk);
        chk("R1 flush_req in reset", int'(flush_req), 0);
        chk("R1 flush_serial in reset", int'(flush_serial), 0);
        step();
        rst_n = 1'b1;
        step();
        chk("R1 flush_req after reset", int'(flush_req), 0);
        chk("R1 flush_serial after reset", int'(flush_serial), 0);

        // Table-driven single-atomic cases (R2, R3, R4, R7).
        for (int v = 0; v < NVEC; v++) run_case(VEC[v][0], VEC[v][1], VEC[v][2]);

        // R5: the second atomic becomes oldest and its timing starts at the release.
        threshold = 6;
        acq_valid = 1'b1; acq_serial = 10; step();        // E0
        acq_valid = 1'b0; step();                         // E1
        acq_valid = 1'b1; acq_serial = 20; step();        // E2
        acq_valid = 1'b0; step();                         // E3
        rel_valid = 1'b1; rel_serial = 10; step();        // E4
        rel_valid = 1'b0;
        early = 0;
        for (int k = 5; k <= 9; k++) begin
            step();
            if (flush_req) early++;
        end
        chk("R5 no flush before restart window ends", early, 0);
        step();                                           // E10
        chk("R5 flush at release edge plus threshold", int'(flush_req), 1);
        chk("R5 serial of new oldest", int'(flush_serial), 20);

        // R8: request held without acknowledgement.
        for (int k = 0; k < 4; k++) step();
        chk("R8 request held", int'(flush_req), 1);
        chk("R8 serial held", int'(flush_serial), 20);

        // R9: acknowledgement clears the still-tracked atomic.
        do_ack();
        early = 0;
        for (int k = 0; k < 12; k++) begin
            step();
            if (flush_req) early++;
        end
        chk("R9 cleared entries never fire", early, 0);

        // R6: releasing the younger atomic leaves the oldest's timing intact.
        threshold = 4;
        acq_valid = 1'b1; acq_serial = 1; step();         // E0
        acq_serial = 2; step();                           // E1
        acq_valid = 1'b0;
        rel_valid = 1'b1; rel_serial = 2; step();         // E2
        rel_valid = 1'b0;
        step();                                           // E3
        chk("R6 no flush before limit", int'(flush_req), 0);
        step();                                           // E4
        chk("R6 oldest fires on time", int'(flush_req), 1);
        chk("R6 oldest serial", int'(flush_serial), 1);
        do_ack();

        summary();
        $finish;
    end
endmodule